// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the slave side of a four-wire boundary-scan test port. The 16-state controller advances on every rising edge of the test clock `tck`, steered by `tms`. It runs two scan paths. The instruction path has a shift stage and a held instruction. The data path reaches one of three registers, chosen by the held instruction. Serial data enters on `tdi` and leaves on `tdo`, least significant bit first.

The three data registers are a one-bit bypass stage, a 32-bit identification register and a user register. The user register has a parallel capture input and a parallel update output, for whatever logic sits behind it. Capture states load the selected register in parallel. Update states commit the shifted value on the falling edge, so parallel outputs never ripple during a scan. `tdo` and its enable `tdo_en` are registered on the falling edge of `tck`. Reset `rst` is active high and sampled on the rising edge of `tck`.

Top module: `jtag_tap_port`

## Requirements
- R1: The controller state changes only on the rising edge of `tck`, following the 16-state scan graph driven by `tms`. `tap_state` encodes: 0 test-logic-reset, 1 run-test/idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R2: Five consecutive rising edges with `tms` high bring the controller to state 0 from any state, and state 0 is held while `tms` stays high.
- R3: With `rst` high at a rising edge, `tap_state` becomes 0. At the following falling edge, `tdo` and `tdo_en` are 0, `user_update` is 0 and `instr` holds the reset instruction.
- R4: In capture-IR the instruction shift stage loads the constant `IR_CAPTURE` (default 4'b0101, ending in binary 01). The next shift-IR therefore shows that value on `tdo`, least significant bit first.
- R5: On the falling edge in update-IR, `instr` takes the value shifted in during shift-IR. In every other state except test-logic-reset, `instr` keeps its value.
- R6: On each falling edge in test-logic-reset, `instr` is loaded with `IDCODE_OP` (default 4'b0010), or with all ones when `HAS_ID` is 0.
- R7: With `IDCODE_OP` selected, capture-DR loads `ID_VALUE` (default 32'h1C0DE0A3), which then shifts out least significant bit first.
- R8: The all-ones instruction selects a one-bit bypass stage that captures 0, so `tdo` carries `tdi` one shift later.
- R9: With `USER_OP` selected (default 4'b1000), capture-DR loads `user_capture`. On the falling edge in update-DR, `user_update` takes the `USER_W` bits shifted in.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly while the state is shift-IR or shift-DR, and `tdo` is 0 whenever `tdo_en` is 0. Each rising edge in a shift state moves the selected register one bit from `tdi` toward `tdo`.
- R11: `user_update` changes only on the falling edge in update-DR with `USER_OP` selected, or on reset. It stays stable throughout capture and shift.
- R12: Any instruction code other than `IDCODE_OP` and `USER_OP` selects the bypass stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; rising edge samples, falling edge updates outputs |
| rst | input | 1 | Active-high reset, sampled on the rising edge of `tck` |
| tms | input | 1 | Mode select, steers the controller state |
| tdi | input | 1 | Serial scan input |
| user_capture | input | USER_W | Parallel value loaded into the user register in capture-DR |
| tdo | output | 1 | Serial scan output, registered on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries scan data |
| user_update | output | USER_W | Parallel output committed in update-DR |
| instr | output | IR_W | Currently held instruction |
| tap_state | output | 4 | Controller state, encoded as in R1 |

## Verification
The properties assume that `rst`, `tms`, `tdi` and `user_capture` change only in the half-period before a rising edge of `tck`, so one value holds across each rising edge and the falling edge that follows. They also assume that `USER_OP` differs from `IDCODE_OP` and from all ones. The bench drives every input from a single task that sets the pins a quarter period before raising `tck` and keeps them until the next call. It leaves the instruction codes at their defaults. Its random walk asserts `rst` only through that same task.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET      = 4'd0,
    ST_IDLE       = 4'd1,
    ST_DR_SELECT  = 4'd2,
    ST_DR_CAPTURE = 4'd3,
    ST_DR_SHIFT   = 4'd4,
    ST_DR_EXIT1   = 4'd5,
    ST_DR_PAUSE   = 4'd6,
    ST_DR_EXIT2   = 4'd7,
    ST_DR_UPDATE  = 4'd8,
    ST_IR_SELECT  = 4'd9,
    ST_IR_CAPTURE = 4'd10,
    ST_IR_SHIFT   = 4'd11,
    ST_IR_EXIT1   = 4'd12,
    ST_IR_PAUSE   = 4'd13,
    ST_IR_EXIT2   = 4'd14,
    ST_IR_UPDATE  = 4'd15
  } tap_state_e;

  localparam int unsigned ID_W = 32;

  // Successor of a controller state for one sampled mode-select bit.
  function automatic tap_state_e tap_next(input tap_state_e cur, input logic sel);
    tap_state_e nxt;
    case (cur)
      ST_RESET:      nxt = sel ? ST_RESET     : ST_IDLE;
      ST_IDLE:       nxt = sel ? ST_DR_SELECT : ST_IDLE;
      ST_DR_SELECT:  nxt = sel ? ST_IR_SELECT : ST_DR_CAPTURE;
      ST_DR_CAPTURE: nxt = sel ? ST_DR_EXIT1  : ST_DR_SHIFT;
      ST_DR_SHIFT:   nxt = sel ? ST_DR_EXIT1  : ST_DR_SHIFT;
      ST_DR_EXIT1:   nxt = sel ? ST_DR_UPDATE : ST_DR_PAUSE;
      ST_DR_PAUSE:   nxt = sel ? ST_DR_EXIT2  : ST_DR_PAUSE;
      ST_DR_EXIT2:   nxt = sel ? ST_DR_UPDATE : ST_DR_SHIFT;
      ST_DR_UPDATE:  nxt = sel ? ST_DR_SELECT : ST_IDLE;
      ST_IR_SELECT:  nxt = sel ? ST_RESET     : ST_IR_CAPTURE;
      ST_IR_CAPTURE: nxt = sel ? ST_IR_EXIT1  : ST_IR_SHIFT;
      ST_IR_SHIFT:   nxt = sel ? ST_IR_EXIT1  : ST_IR_SHIFT;
      ST_IR_EXIT1:   nxt = sel ? ST_IR_UPDATE : ST_IR_PAUSE;
      ST_IR_PAUSE:   nxt = sel ? ST_IR_EXIT2  : ST_IR_PAUSE;
      ST_IR_EXIT2:   nxt = sel ? ST_IR_UPDATE : ST_IR_SHIFT;
      ST_IR_UPDATE:  nxt = sel ? ST_DR_SELECT : ST_IDLE;
      default:       nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         tdi,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);

  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      always_comb shifted = tdi;
    end else begin : g_multi
      always_comb shifted = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck) begin
    if (rst)           q <= '0;
    else if (cap_en)   q <= cap_val;
    else if (shift_en) q <= shifted;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int unsigned          IR_W       = 4,
  parameter logic [IR_W-1:0]      CAPTURE    = IR_W'(5),
  parameter logic [IR_W-1:0]      RESET_CODE = IR_W'(2)
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] instr
);

  tap_shreg #(.W(IR_W)) u_stage (
    .tck      (tck),
    .rst      (rst),
    .tdi      (tdi),
    .cap_en   (state == ST_IR_CAPTURE),
    .shift_en (state == ST_IR_SHIFT),
    .cap_val  (CAPTURE),
    .q        (ir_shift)
  );

  // Held instruction changes on the falling edge only.
  always_ff @(negedge tck) begin
    if (rst || state == ST_RESET)   instr <= RESET_CODE;
    else if (state == ST_IR_UPDATE) instr <= ir_shift;
  end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W      = 4,
  parameter int unsigned     USER_W    = 12,
  parameter bit              HAS_ID    = 1'b1,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h1C0D_E0A3,
  parameter logic [IR_W-1:0] IDCODE_OP = IR_W'(2),
  parameter logic [IR_W-1:0] USER_OP   = IR_W'(8)
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tdi,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   instr,
  input  logic [USER_W-1:0] user_capture,
  output logic              dr_tdo,
  output logic [USER_W-1:0] user_update
);

  logic sel_id, sel_user, sel_byp;
  logic cap, shf;
  logic byp_q;
  logic id_bit;
  logic [USER_W-1:0] usr_q;

  assign sel_id   = HAS_ID && (instr == IDCODE_OP);
  assign sel_user = (instr == USER_OP);
  assign sel_byp  = !sel_id && !sel_user;
  assign cap      = (state == ST_DR_CAPTURE);
  assign shf      = (state == ST_DR_SHIFT);

  tap_shreg #(.W(1)) u_byp (
    .tck(tck), .rst(rst), .tdi(tdi),
    .cap_en(cap && sel_byp), .shift_en(shf && sel_byp),
    .cap_val(1'b0), .q(byp_q)
  );

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_q;
      tap_shreg #(.W(ID_W)) u_id (
        .tck(tck), .rst(rst), .tdi(tdi),
        .cap_en(cap && sel_id), .shift_en(shf && sel_id),
        .cap_val(ID_VALUE), .q(id_q)
      );
      assign id_bit = id_q[0];
    end else begin : g_no_id
      assign id_bit = 1'b0;
    end
  endgenerate

  tap_shreg #(.W(USER_W)) u_usr (
    .tck(tck), .rst(rst), .tdi(tdi),
    .cap_en(cap && sel_user), .shift_en(shf && sel_user),
    .cap_val(user_capture), .q(usr_q)
  );

  always_ff @(negedge tck) begin
    if (rst)                                     user_update <= '0;
    else if (state == ST_DR_UPDATE && sel_user)  user_update <= usr_q;
  end

  always_comb begin
    if (sel_id)        dr_tdo = id_bit;
    else if (sel_user) dr_tdo = usr_q[0];
    else               dr_tdo = byp_q;
  end

endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W       = 4,
  parameter int unsigned     USER_W     = 12,
  parameter bit              HAS_ID     = 1'b1,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h1C0D_E0A3,
  parameter logic [IR_W-1:0] IR_CAPTURE = IR_W'(5),
  parameter logic [IR_W-1:0] IDCODE_OP  = IR_W'(2),
  parameter logic [IR_W-1:0] USER_OP    = IR_W'(8)
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  input  logic [USER_W-1:0] user_capture,
  output logic              tdo,
  output logic              tdo_en,
  output logic [USER_W-1:0] user_update,
  output logic [IR_W-1:0]   instr,
  output logic [3:0]        tap_state
);

  localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? IDCODE_OP : {IR_W{1'b1}};

  tap_state_e        fsm_state;
  logic [IR_W-1:0]   ir_shift;
  logic              dr_tdo;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (fsm_state)
  );

  tap_ir #(
    .IR_W       (IR_W),
    .CAPTURE    (IR_CAPTURE),
    .RESET_CODE (RESET_OP)
  ) u_ir (
    .tck      (tck),
    .rst      (rst),
    .tdi      (tdi),
    .state    (fsm_state),
    .ir_shift (ir_shift),
    .instr    (instr)
  );

  tap_dr #(
    .IR_W      (IR_W),
    .USER_W    (USER_W),
    .HAS_ID    (HAS_ID),
    .ID_VALUE  (ID_VALUE),
    .IDCODE_OP (IDCODE_OP),
    .USER_OP   (USER_OP)
  ) u_dr (
    .tck          (tck),
    .rst          (rst),
    .tdi          (tdi),
    .state        (fsm_state),
    .instr        (instr),
    .user_capture (user_capture),
    .dr_tdo       (dr_tdo),
    .user_update  (user_update)
  );

  // Output mux, retimed to the falling edge.
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      case (fsm_state)
        ST_IR_SHIFT: begin tdo <= ir_shift[0]; tdo_en <= 1'b1; end
        ST_DR_SHIFT: begin tdo <= dr_tdo;      tdo_en <= 1'b1; end
        default:     begin tdo <= 1'b0;        tdo_en <= 1'b0; end
      endcase
    end
  end

  assign tap_state = fsm_state;

endmodule

// File: rtl/tap_checks.sv
module tap_checks
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W       = 4,
  parameter int unsigned     USER_W     = 12,
  parameter logic [IR_W-1:0] RESET_CODE = IR_W'(2)
) (
  input logic              tck,
  input logic              rst,
  input logic              tms,
  input tap_state_e        state,
  input logic [IR_W-1:0]   instr,
  input logic [IR_W-1:0]   ir_shift,
  input logic              tdo_en,
  input logic [USER_W-1:0] user_update
);

  logic [2:0] ones_cnt;
  logic       armed;

  always_ff @(posedge tck) begin
    armed <= !rst;
    if (rst)           ones_cnt <= '0;
    else if (!tms)     ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  p_reset_state_r3: assert property (@(posedge tck) rst |=> state == ST_RESET);

  p_five_ones_r2: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == 3'd5) |-> (state == ST_RESET));

  p_tlr_hold_r2: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET && tms) |=> (state == ST_RESET));

  p_capture_ir_r4: assert property (@(posedge tck) disable iff (rst)
    (state == ST_IR_CAPTURE) |=> (ir_shift[1:0] == 2'b01));

  p_ir_update_r5: assert property (@(posedge tck) disable iff (rst || !armed)
    (state == ST_IR_UPDATE) |-> (instr == ir_shift));

  p_tlr_instr_r6: assert property (@(posedge tck) disable iff (rst || !armed)
    (state == ST_RESET) |-> (instr == RESET_CODE));

  p_tdo_en_r10: assert property (@(posedge tck) disable iff (rst || !armed)
    tdo_en == (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

  p_user_stable_r11: assert property (@(posedge tck) disable iff (rst || !armed)
    (state != ST_DR_UPDATE) |-> $stable(user_update));

endmodule

bind jtag_tap_port tap_checks #(
  .IR_W       (IR_W),
  .USER_W     (USER_W),
  .RESET_CODE (RESET_OP)
) u_checks (
  .tck         (tck),
  .rst         (rst),
  .tms         (tms),
  .state       (fsm_state),
  .instr       (instr),
  .ir_shift    (ir_shift),
  .tdo_en      (tdo_en),
  .user_update (user_update)
);

// File: tb/test_jtag_tap_port.sv
module test_jtag_tap_port;

  localparam int CLK_PERIOD = 20;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int IR_W       = 4;
  localparam int USER_W     = 12;
  localparam logic [31:0]       ID_VAL  = 32'h1C0D_E0A3;
  localparam logic [IR_W-1:0]   CAP_VAL = 4'b0101;
  localparam logic [IR_W-1:0]   OP_ID   = 4'b0010;
  localparam logic [IR_W-1:0]   OP_USER = 4'b1000;
  localparam logic [IR_W-1:0]   OP_BYP  = 4'b1111;

  logic              tck = 1'b0;
  logic              rst = 1'b1;
  logic              tms = 1'b1;
  logic              tdi = 1'b0;
  logic [USER_W-1:0] user_capture = '0;
  logic              tdo, tdo_en;
  logic [USER_W-1:0] user_update;
  logic [IR_W-1:0]   instr;
  logic [3:0]        tap_state;

  jtag_tap_port #(
    .IR_W(IR_W), .USER_W(USER_W), .HAS_ID(1'b1), .ID_VALUE(ID_VAL),
    .IR_CAPTURE(CAP_VAL), .IDCODE_OP(OP_ID), .USER_OP(OP_USER)
  ) i_jtag_tap_port (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .user_capture(user_capture),
    .tdo(tdo), .tdo_en(tdo_en), .user_update(user_update),
    .instr(instr), .tap_state(tap_state)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference
  int   m_state;
  bit   irq[$];
  bit   drq[$];
  logic [IR_W-1:0]   m_instr;
  logic [USER_W-1:0] m_user;
  bit   m_tdo, m_en;
  bit   mon_user = 0;
  logic [USER_W-1:0] mon_val;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nxt(input int s, input bit t);
    int r;
    case (s)
      0: r = t ? 0 : 1;    1: r = t ? 2 : 1;
      2: r = t ? 9 : 3;    3: r = t ? 5 : 4;
      4: r = t ? 5 : 4;    5: r = t ? 8 : 6;
      6: r = t ? 7 : 6;    7: r = t ? 8 : 4;
      8: r = t ? 2 : 1;    9: r = t ? 0 : 10;
      10: r = t ? 12 : 11; 11: r = t ? 12 : 11;
      12: r = t ? 15 : 13; 13: r = t ? 14 : 13;
      14: r = t ? 15 : 11; default: r = t ? 2 : 1;
    endcase
    return r;
  endfunction

  task automatic model_rise();
    if (rst) begin
      m_state = 0;
      return;
    end
    if (m_state == 10) begin
      irq.delete();
      for (int i = 0; i < IR_W; i++) irq.push_back(CAP_VAL[i]);
    end else if (m_state == 11) begin
      void'(irq.pop_front());
      irq.push_back(tdi);
    end else if (m_state == 3) begin
      drq.delete();
      if (m_instr == OP_ID)        for (int i = 0; i < 32; i++) drq.push_back(ID_VAL[i]);
      else if (m_instr == OP_USER) for (int i = 0; i < USER_W; i++) drq.push_back(user_capture[i]);
      else                         drq.push_back(1'b0);
    end else if (m_state == 4) begin
      void'(drq.pop_front());
      drq.push_back(tdi);
    end
    m_state = nxt(m_state, tms);
  endtask

  task automatic model_fall();
    if (rst) begin
      m_instr = OP_ID; m_user = '0; m_tdo = 0; m_en = 0;
      return;
    end
    m_en  = (m_state == 11 || m_state == 4);
    m_tdo = (m_state == 11) ? irq[0] : (m_state == 4) ? drq[0] : 1'b0;
    if (m_state == 0) m_instr = OP_ID;
    if (m_state == 15) for (int i = 0; i < IR_W; i++) m_instr[i] = irq[i];
    if (m_state == 8 && m_instr == OP_USER)
      for (int i = 0; i < USER_W; i++) m_user[i] = drq[i];
  endtask

  task automatic step(input bit t_ms, input bit t_di);
    tms = t_ms;
    tdi = t_di;
    #(QTR);
    model_rise();
    tck = 1'b1;
    #(QTR);
    chk("R1 state", tap_state, m_state);
    #(QTR);
    tck = 1'b0;
    model_fall();
    #(QTR);
    chk("R10 tdo", tdo, m_tdo);
    chk("R10 tdo_en", tdo_en, m_en);
    chk("R5 instr", instr, m_instr);
    chk("R11 user_update", user_update, m_user);
    if (mon_user && tap_state == 4'd4) chk("R11 stable in shift", user_update, mon_val);
  endtask

  task automatic ir_scan(input logic [IR_W-1:0] code, output logic [63:0] outv);
    outv = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    outv[0] = tdo;
    for (int i = 0; i < IR_W; i++) begin
      step(i == IR_W - 1, code[i]);
      if (i < IR_W - 1) outv[i+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] inv, output logic [63:0] outv);
    outv = '0;
    step(1, 0); step(0, 0); step(0, 0);
    outv[0] = tdo;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, inv[i]);
      if (i < n - 1) outv[i+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] o;
    logic [15:0] lfsr;
    m_state = 0; m_instr = OP_ID; m_user = '0; m_tdo = 0; m_en = 0;

    // Reset
    step(1, 0); step(1, 0);
    chk("R3 state after rst", tap_state, 0);
    chk("R3 tdo_en after rst", tdo_en, 0);
    chk("R3 tdo after rst", tdo, 0);
    chk("R3 user_update after rst", user_update, 0);
    chk("R6 instr after rst", instr, OP_ID);
    rst = 1'b0;
    step(1, 0);
    chk("R2 hold in reset", tap_state, 0);
    step(0, 0);
    chk("R1 reset to idle", tap_state, 1);

    // Identification register
    dr_scan(32, 64'h0, o);
    chk("R7 id value", o[31:0], ID_VAL);

    // Instruction capture and update
    ir_scan(OP_USER, o);
    chk("R4 ir capture", o[IR_W-1:0], CAP_VAL);
    chk("R4 ir capture low bits", o[1:0], 2'b01);
    chk("R5 instr after update", instr, OP_USER);

    // User register
    user_capture = 12'hA5C;
    dr_scan(USER_W, 64'h3E1, o);
    chk("R9 user capture", o[USER_W-1:0], 12'hA5C);
    chk("R9 user update", user_update, 12'h3E1);
    user_capture = 12'h0F0;
    mon_val = 12'h3E1;
    mon_user = 1;
    dr_scan(USER_W, 64'h777, o);
    mon_user = 0;
    chk("R9 user capture 2", o[USER_W-1:0], 12'h0F0);
    chk("R9 user update 2", user_update, 12'h777);

    // Bypass
    ir_scan(OP_BYP, o);
    chk("R5 instr bypass", instr, OP_BYP);
    dr_scan(8, 64'hB2, o);
    chk("R8 bypass delay", o[7:0], 8'h64);
    chk("R11 user untouched by bypass", user_update, 12'h777);

    // Unknown code
    ir_scan(4'b0110, o);
    dr_scan(8, 64'h5B, o);
    chk("R12 unknown selects bypass", o[7:0], 8'hB6);

    // Five ones from assorted states
    lfsr = 16'hACE1;
    for (int k = 0; k < 24; k++) begin
      for (int j = 0; j < (k % 9); j++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0], lfsr[5]);
      end
      for (int j = 0; j < 5; j++) step(1, 0);
      chk("R2 five ones", tap_state, 0);
      chk("R6 instr in reset", instr, OP_ID);
    end

    // Random walk against the reference
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) user_capture = lfsr[15:4];
      rst = (lfsr[15:8] == 8'h00);
      step(lfsr[0] & (lfsr[6] | lfsr[9]), lfsr[5]);
    end
    rst = 1'b0;
    for (int j = 0; j < 5; j++) step(1, 0);
    chk("R2 final reset", tap_state, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule